// File: doc/BRIEF.md
# NaN Propagation Selector

This unit decides which NaN becomes the result of a two-input floating-point operation when at least one of the operands is a NaN. It accepts two operand words in binary32 format (low 32 bits) or binary64 format. It classifies each operand as a number, a quiet NaN or a signaling NaN. It then applies one of four run-time selectable choice policies and returns the chosen NaN, made quiet if it was signaling. An invalid flag is raised whenever either input is signaling.

The NaN convention is set at run time. Either a clear or a set top fraction bit marks a signaling NaN, or signaling NaNs are disabled altogether. A default-NaN mode replaces any propagated payload with the canonical NaN. The arithmetic datapath alongside computes the non-NaN results. It uses this block only to settle NaN results. The result and the flag are registered, so they appear one clock after the inputs.

Top module: `nan_pick_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is non-zero. With `no_snan`=1 every NaN is quiet. Otherwise a NaN is signaling when its top fraction bit (bit 22 for binary32, bit 51 for binary64) equals `snan_one`. `invalid` is 1 exactly when either operand is signaling, and this holds in default-NaN mode too.
- R2: With `dflt_mode`=1 the result is the default NaN: sign 0, exponent all ones, top fraction bit equal to NOT `snan_one`, and all other fraction bits equal to `snan_one`. For binary32 this is 0x7FC00000 or 0x7FBFFFFF, and for binary64 it is 0x7FF8000000000000 or 0x7FF7FFFFFFFFFFFF.
- R3: With `rule`=2'b00 (fixed priority) the choice is made in this order: A if signaling, else B if signaling, else A if quiet, else B.
- R4: With `rule`=2'b01 (first NaN) the result is A when A is any NaN, otherwise B.
- R5: With `rule`=2'b10 (two-way), when `prefer_first`=1 the result is A if A is a NaN, otherwise B. When `prefer_first`=0 the result is B if B is a NaN, otherwise A.
- R6: With `rule`=2'b11 (largest significand), a signaling NaN paired with a quiet NaN yields the quiet one. A NaN paired with a non-NaN yields the NaN.
- R7: With `rule`=2'b11 and both operands NaNs of the same kind, the operand whose word with the sign removed is numerically larger wins. On equality, a positive operand wins over a negative one.
- R8: A chosen signaling NaN is made quiet before output. With `snan_one`=0 its top fraction bit is set and the rest of the word is kept. With `snan_one`=1 the default NaN is returned.
- R9: Results appear one clock after the inputs. In binary32 mode bits 63:32 of `result` are 0. While reset is held, and until it is released, `result` and `invalid` are 0.
- R10: If neither operand is a NaN, the result is the default NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | 64 | First operand (binary32 uses bits 31:0) |
| op_b | input | 64 | Second operand (binary32 uses bits 31:0) |
| is_dbl | input | 1 | 1 = binary64, 0 = binary32 |
| rule | input | 2 | Choice policy: 00 fixed, 01 first NaN, 10 two-way, 11 largest significand |
| prefer_first | input | 1 | Direction of the two-way policy |
| dflt_mode | input | 1 | Force the default NaN result |
| snan_one | input | 1 | Value of the top fraction bit that marks a signaling NaN |
| no_snan | input | 1 | Treat every NaN as quiet |
| result | output | 64 | Selected NaN, registered |
| invalid | output | 1 | Invalid-operation flag, registered |

## Verification
The sweep pairs NaNs of equal magnitude but opposite sign. A design that drops the sign tie-break returns the negative operand under the largest-significand policy. It also pairs infinity with a NaN whose fraction is only the top bit. Infinity must never count as a NaN, and under the inverted convention that top-bit-only NaN is signaling. A flag gated by default-NaN mode would clear `invalid` exactly where the bench still expects it. Quieting under the inverted convention must produce the default NaN rather than a set bit, so a design that merely sets the bit is caught.

// File: rtl/nan_pick_pkg.sv
package nan_pick_pkg;
  localparam int WORD_W    = 64;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = SP_W - SP_EXP_W - 1;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = WORD_W - DP_EXP_W - 1;
  localparam int NUM_OPS   = 2;

  typedef enum logic [1:0] {
    RULE_FIXED  = 2'b00,
    RULE_FIRST  = 2'b01,
    RULE_TWOWAY = 2'b10,
    RULE_MAGN   = 2'b11
  } rule_e;

  typedef enum logic [1:0] {
    K_NUM   = 2'd0,
    K_QUIET = 2'd1,
    K_SIG   = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e                kind;
    logic                 sgn;
    logic [WORD_W-2:0]    mag;
  } opnd_t;

  function automatic logic [WORD_W-1:0] default_nan(logic dbl, logic s1);
    logic [WORD_W-1:0] w;
    if (dbl)
      w = {1'b0, {DP_EXP_W{1'b1}}, ~s1, {(DP_FRAC_W-1){s1}}};
    else
      w = {{(WORD_W-SP_W){1'b0}}, 1'b0, {SP_EXP_W{1'b1}}, ~s1, {(SP_FRAC_W-1){s1}}};
    return w;
  endfunction
endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
  import nan_pick_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] word,
  input  logic         snan_one,
  input  logic         no_snan,
  output kind_e        kind
);
  logic exp_ones, frac_nz, top_bit, is_nan;

  always_comb begin
    exp_ones = &word[W-2:FRAC_W];
    frac_nz  = |word[FRAC_W-1:0];
    top_bit  = word[FRAC_W-1];
    is_nan   = exp_ones & frac_nz;
    if (!is_nan)
      kind = K_NUM;
    else if (!no_snan && (top_bit == snan_one))
      kind = K_SIG;
    else
      kind = K_QUIET;
  end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick
  import nan_pick_pkg::*;
(
  input  rule_e rule,
  input  logic  prefer_first,
  input  opnd_t opa,
  input  opnd_t opb,
  output logic  take_b
);
  logic a_nan, b_nan, a_sig, b_sig, a_q, b_q, a_larger;

  always_comb begin
    a_sig = (opa.kind == K_SIG);
    b_sig = (opb.kind == K_SIG);
    a_q   = (opa.kind == K_QUIET);
    b_q   = (opb.kind == K_QUIET);
    a_nan = a_sig | a_q;
    b_nan = b_sig | b_q;
    a_larger = (opa.mag > opb.mag) |
               ((opa.mag == opb.mag) & ~opa.sgn & opb.sgn);
    unique case (rule)
      RULE_FIXED:  take_b = ~a_sig & (b_sig | ~a_q);
      RULE_FIRST:  take_b = ~a_nan;
      RULE_TWOWAY: take_b = prefer_first ? ~a_nan : b_nan;
      RULE_MAGN: begin
        if (a_sig)
          take_b = b_sig ? ~a_larger : b_q;
        else if (a_q)
          take_b = b_q ? ~a_larger : 1'b0;
        else
          take_b = 1'b1;
      end
      default:     take_b = 1'b0;
    endcase
  end
endmodule

// File: rtl/nanp_form.sv
module nanp_form
  import nan_pick_pkg::*;
(
  input  logic [WORD_W-1:0] chosen,
  input  kind_e             chosen_kind,
  input  logic              is_dbl,
  input  logic              snan_one,
  input  logic              dflt_mode,
  input  logic              any_nan,
  output logic [WORD_W-1:0] res
);
  logic [WORD_W-1:0] dnan, fmt_word, quiet_bit;

  always_comb begin
    dnan      = default_nan(is_dbl, snan_one);
    fmt_word  = is_dbl ? chosen : {{(WORD_W-SP_W){1'b0}}, chosen[SP_W-1:0]};
    quiet_bit = is_dbl ? (WORD_W'(1) << (DP_FRAC_W-1)) : (WORD_W'(1) << (SP_FRAC_W-1));
    if (dflt_mode || !any_nan)
      res = dnan;
    else if (chosen_kind == K_SIG)
      res = snan_one ? dnan : (fmt_word | quiet_bit);
    else
      res = fmt_word;
  end
endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit
  import nan_pick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              is_dbl,
  input  logic [1:0]        rule,
  input  logic              prefer_first,
  input  logic              dflt_mode,
  input  logic              snan_one,
  input  logic              no_snan,
  output logic [WORD_W-1:0] result,
  output logic              invalid
);
  logic [1:0]        rs_q;
  logic              rst_q;
  logic [WORD_W-1:0] words [NUM_OPS];
  opnd_t             opd   [NUM_OPS];
  logic              take_b, any_nan, inv_d;
  logic [WORD_W-1:0] chosen, res_d, res_q;
  kind_e             chosen_kind;
  logic              inv_q;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  assign words[0] = op_a;
  assign words[1] = op_b;

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_op
    kind_e k_sp, k_dp;
    nanp_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_sp (
      .word(words[gi][SP_W-1:0]), .snan_one(snan_one), .no_snan(no_snan), .kind(k_sp));
    nanp_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dp (
      .word(words[gi]), .snan_one(snan_one), .no_snan(no_snan), .kind(k_dp));
    always_comb begin
      opd[gi].kind = is_dbl ? k_dp : k_sp;
      opd[gi].sgn  = is_dbl ? words[gi][WORD_W-1] : words[gi][SP_W-1];
      opd[gi].mag  = is_dbl ? words[gi][WORD_W-2:0]
                            : {{(WORD_W-SP_W){1'b0}}, words[gi][SP_W-2:0]};
    end
  end

  nanp_pick u_pick (
    .rule(rule_e'(rule)), .prefer_first(prefer_first),
    .opa(opd[0]), .opb(opd[1]), .take_b(take_b));

  always_comb begin
    chosen      = take_b ? words[1] : words[0];
    chosen_kind = take_b ? opd[1].kind : opd[0].kind;
    any_nan     = (opd[0].kind != K_NUM) | (opd[1].kind != K_NUM);
    inv_d       = (opd[0].kind == K_SIG) | (opd[1].kind == K_SIG);
  end

  nanp_form u_form (
    .chosen(chosen), .chosen_kind(chosen_kind), .is_dbl(is_dbl),
    .snan_one(snan_one), .dflt_mode(dflt_mode), .any_nan(any_nan), .res(res_d));

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      res_q <= '0;
      inv_q <= 1'b0;
    end else begin
      res_q <= res_d;
      inv_q <= inv_d;
    end
  end

  assign result  = res_q;
  assign invalid = inv_q;
endmodule

// File: rtl/nan_pick_chk.sv
module nan_pick_chk
  import nan_pick_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              is_dbl,
  input logic [1:0]        rule,
  input logic              prefer_first,
  input logic              dflt_mode,
  input logic              snan_one,
  input logic              no_snan,
  input logic [WORD_W-1:0] result,
  input logic              invalid
);
  logic a_sp_sig0, a_sp_q0, b_sp_q0;
  assign a_sp_sig0 = (op_a[30:22] == 9'h1FE) && (op_a[21:0] != 0);
  assign a_sp_q0   = (op_a[30:22] == 9'h1FF);
  assign b_sp_q0   = (op_b[30:22] == 9'h1FF);

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !is_dbl |=> (result[63:32] == 32'h0));

  assert_sp_is_nan_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !is_dbl |=> ((result[30:23] == 8'hFF) && (result[22:0] != 0)));

  assert_dflt_R2: assert property (@(posedge clk) disable iff (!rst_q)
    dflt_mode |=> (result == default_nan($past(is_dbl), $past(snan_one))));

  assert_no_snan_R1: assert property (@(posedge clk) disable iff (!rst_q)
    no_snan |=> !invalid);

  assert_sig_flag_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (!no_snan && !snan_one && !is_dbl && a_sp_sig0) |=> invalid);

  assert_first_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (rule == 2'b01 && !dflt_mode && !no_snan && !snan_one && !is_dbl && a_sp_q0)
      |=> (result == {32'h0, $past(op_a[31:0])}));

  assert_twoway_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (rule == 2'b10 && !prefer_first && !dflt_mode && !no_snan && !snan_one &&
     !is_dbl && b_sp_q0) |=> (result == {32'h0, $past(op_b[31:0])}));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (rule == 2'b01 && !dflt_mode && !no_snan && !snan_one && !is_dbl && a_sp_sig0)
      |=> (result == {32'h0, $past(op_a[31:0]) | 32'h0040_0000}));
endmodule

bind nan_pick_unit nan_pick_chk u_chk (
  .clk(clk), .rst_q(rst_q), .op_a(op_a), .op_b(op_b), .is_dbl(is_dbl),
  .rule(rule), .prefer_first(prefer_first), .dflt_mode(dflt_mode),
  .snan_one(snan_one), .no_snan(no_snan), .result(result), .invalid(invalid));

// File: tb/sim_nan_pick_unit.sv
module sim_nan_pick_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic        is_dbl, prefer_first, dflt_mode, snan_one, no_snan;
  logic [1:0]  rule;
  logic [63:0] result;
  logic        invalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nan_pick_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .is_dbl(is_dbl),
    .rule(rule), .prefer_first(prefer_first), .dflt_mode(dflt_mode),
    .snan_one(snan_one), .no_snan(no_snan), .result(result), .invalid(invalid));

  // operand menu: sign, exponent all ones, top fraction bit, low fraction
  function automatic logic [63:0] mk(int idx, bit dbl);
    bit s, ex, m;
    int lo;
    case (idx)
      0: begin s = 0; ex = 0; m = 0; lo = 0; end
      1: begin s = 1; ex = 0; m = 1; lo = 9; end
      2: begin s = 0; ex = 1; m = 1; lo = 1; end
      3: begin s = 0; ex = 1; m = 1; lo = 5; end
      4: begin s = 1; ex = 1; m = 1; lo = 5; end
      5: begin s = 0; ex = 1; m = 0; lo = 3; end
      6: begin s = 1; ex = 1; m = 0; lo = 7; end
      7: begin s = 1; ex = 1; m = 0; lo = 3; end
      8: begin s = 0; ex = 1; m = 0; lo = 0; end
      default: begin s = 1; ex = 1; m = 1; lo = 0; end
    endcase
    if (dbl) return {s, (ex ? 11'h7FF : 11'h3FF), m, 51'(lo)};
    return {32'h0, s, (ex ? 8'hFF : 8'h7F), m, 22'(lo)};
  endfunction

  // 0 number, 1 quiet, 2 signaling
  function automatic int kind_of(logic [63:0] w, bit dbl, bit s1, bit ns);
    bit nan, top;
    if (dbl) begin nan = (w[62:52] == 11'h7FF) && (w[51:0] != 0); top = w[51]; end
    else     begin nan = (w[30:23] == 8'hFF)   && (w[22:0] != 0); top = w[22]; end
    if (!nan) return 0;
    if (!ns && top == s1) return 2;
    return 1;
  endfunction

  function automatic logic [63:0] dnan(bit dbl, bit s1);
    if (dbl) return s1 ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000;
    return s1 ? 64'h0000_0000_7FBF_FFFF : 64'h0000_0000_7FC0_0000;
  endfunction

  task automatic run_one(bit dbl, int md, int rl, bit pf, bit dm, int ia, int ib);
    logic [63:0] a, b, pick, exp_res, ka_mag, kb_mag;
    int ka, kb, kp;
    bit exp_inv, pick_b, a_big;
    string tag;
    a = mk(ia, dbl);
    b = mk(ib, dbl);
    @(negedge clk);
    op_a = a; op_b = b; is_dbl = dbl; rule = 2'(rl); prefer_first = pf;
    dflt_mode = dm; snan_one = (md == 1); no_snan = (md == 2);
    ka = kind_of(a, dbl, md == 1, md == 2);
    kb = kind_of(b, dbl, md == 1, md == 2);
    exp_inv = (ka == 2) || (kb == 2);
    ka_mag = dbl ? {1'b0, a[62:0]} : {33'h0, a[30:0]};
    kb_mag = dbl ? {1'b0, b[62:0]} : {33'h0, b[30:0]};
    a_big = (ka_mag > kb_mag) || (ka_mag == kb_mag && !(dbl ? a[63] : a[31]) && (dbl ? b[63] : b[31]));
    case (rl)
      0: pick_b = (ka == 2) ? 0 : (kb == 2) ? 1 : (ka == 1) ? 0 : 1;
      1: pick_b = (ka == 0);
      2: pick_b = pf ? (ka == 0) : (kb != 0);
      default: begin
        if (ka != 0 && kb != 0 && ka != kb) pick_b = (kb == 1);
        else if (ka == 0) pick_b = 1;
        else if (kb == 0) pick_b = 0;
        else pick_b = !a_big;
      end
    endcase
    pick = pick_b ? b : a;
    kp = pick_b ? kb : ka;
    if (ka == 0 && kb == 0) begin exp_res = dnan(dbl, md == 1); tag = "R10"; end
    else if (dm) begin exp_res = dnan(dbl, md == 1); tag = "R2"; end
    else if (kp == 2) begin
      exp_res = (md == 1) ? dnan(dbl, 1) : (pick | (dbl ? 64'h0008_0000_0000_0000 : 64'h0040_0000));
      tag = "R8";
    end else begin
      exp_res = pick;
      case (rl)
        0: tag = "R3";
        1: tag = "R4";
        2: tag = "R5";
        default: tag = (ka != 0 && kb != 0 && ka == kb) ? "R7" : "R6";
      endcase
    end
    @(posedge clk);
    #1;
    checks++;
    if (result !== exp_res) begin
      errors++;
      $display("FAIL %s/R9 result dbl=%0d mode=%0d rule=%0d a=%h b=%h got %h exp %h",
               tag, dbl, md, rl, a, b, result, exp_res);
    end
    checks++;
    if (invalid !== exp_inv) begin
      errors++;
      $display("FAIL R1 invalid a=%h b=%h got %0d exp %0d", a, b, invalid, exp_inv);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_a = 64'h0; op_b = 64'h0; is_dbl = 1'b0; rule = 2'b00;
    prefer_first = 1'b0; dflt_mode = 1'b0; snan_one = 1'b0; no_snan = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R9 reset state
    if (result !== 64'h0 || invalid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset got %h/%0d exp 0/0", result, invalid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int f = 0; f < 2; f++)
      for (int md = 0; md < 3; md++)
        for (int rl = 0; rl < 4; rl++)
          for (int pf = 0; pf < 2; pf++)
            for (int dm = 0; dm < 2; dm++)
              for (int ia = 0; ia < 10; ia++)
                for (int ib = 0; ib < 10; ib++)
                  run_one(f[0], md, rl, pf[0], dm[0], ia, ib);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule